// File: doc/BRIEF.md
# Rejected Interrupt Replay Bitmap

The block keeps a record of interrupts that the downstream presenter turned away, and hands them back for delivery later. A reject carries a global interrupt number. The block subtracts a programmable base, and the resulting local source number selects one bit in a two-level store. The store has `ROWS` rows of `ROW_W` bits each, plus one summary bit per row that is set whenever its row gains an entry.

A resend request starts a scan. The scan uses the summary to skip empty rows. On entering a row it clears that row's summary bit, then walks the row's bits from low to high. Each recorded bit is cleared and presented once on a valid/ready trigger port as a forced replay of that source. The downstream sender receives the trigger and ignores its own pending/queued state for it. Rejects keep being accepted while a scan runs. Reset empties the whole store.

Top module: `rr_replay`

## Requirements
- R1: A reject of global number N with N >= base_i records local source S = N - base_i at row S>>6 (S[10:6]) and bit S[5:0], and sets that row's summary bit; a later resend replays S on send_src_o.
- R2: A reject with N < base_i or N - base_i >= ROWS*ROW_W (2048) records nothing; a following resend issues no trigger.
- R3: A resend request while the summary is all zero issues no trigger.
- R4: One scan replays recorded sources in ascending row-major order (row, then bit), skipping rows whose summary bit is clear.
- R5: Each replayed source is cleared from the store, so it is issued exactly once; a second resend with nothing new recorded issues no trigger.
- R6: While send_valid_o is high and send_ready_i is low, send_valid_o stays high and send_src_o holds its value; a trigger completes on a cycle with both high.
- R7: A reject that arrives during a scan is kept: if its row (or its position in the current row) is still ahead of the scan it is replayed in the same scan, otherwise it waits for the next resend.
- R8: Reset clears every recorded bit and every summary bit; send_valid_o is low during and right after reset.
- R9: A resend request that arrives while a scan is in progress is ignored and does not restart or duplicate the scan.
- R10: Rejecting the same source several times before a resend yields a single replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | IRQ_W | Global number of local source 0 |
| rej_valid_i | input | 1 | Reject strobe, one per cycle |
| rej_irq_i | input | IRQ_W | Global number of the rejected interrupt |
| resend_i | input | 1 | Request to replay all recorded sources |
| send_valid_o | output | 1 | Forced replay trigger is valid |
| send_ready_i | input | 1 | Downstream accepts the trigger |
| send_src_o | output | SRC_W | Local source number to replay |

## Verification
The embedded assertions check several behaviours on every cycle. The trigger holds its value under backpressure. An accepted reject shows up in both its row bit and its summary bit one cycle later. Every bit the scan clears was really recorded. A resend against an empty summary leaves the scanner idle. The directed scenarios are needed for the rest: end-to-end replay order, the range filter on the offset, once-only delivery, ignored resends during a scan, and the fate of rejects that land behind or ahead of a running scan. Those depend on whole sequences of triggers, not on single cycles.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROW,
    ST_BIT,
    ST_OUT
  } scan_st_e;
endpackage

// File: rtl/rr_decode.sv
module rr_decode #(
  parameter int ROWS  = 32,
  parameter int ROW_W = 64,
  parameter int IRQ_W = 20,
  localparam int ROW_IW = $clog2(ROWS),
  localparam int BIT_W  = $clog2(ROW_W),
  localparam int SRC_W  = ROW_IW + BIT_W
) (
  input  logic              rej_valid_i,
  input  logic [IRQ_W-1:0]  rej_irq_i,
  input  logic [IRQ_W-1:0]  base_i,
  output logic              set_en_o,
  output logic [ROW_IW-1:0] set_row_o,
  output logic [BIT_W-1:0]  set_bit_o
);
  localparam int NSRC = ROWS * ROW_W;

  logic [IRQ_W-1:0] diff;
  logic             in_rng;

  assign diff      = rej_irq_i - base_i;
  assign in_rng    = (rej_irq_i >= base_i) && (diff < IRQ_W'(NSRC));
  assign set_en_o  = rej_valid_i && in_rng;
  assign set_row_o = diff[SRC_W-1:BIT_W];
  assign set_bit_o = diff[BIT_W-1:0];
endmodule

// File: rtl/rr_bitmap.sv
module rr_bitmap #(
  parameter int ROWS  = 32,
  parameter int ROW_W = 64,
  localparam int ROW_IW = $clog2(ROWS),
  localparam int BIT_W  = $clog2(ROW_W)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       set_en_i,
  input  logic [ROW_IW-1:0]          set_row_i,
  input  logic [BIT_W-1:0]           set_bit_i,
  input  logic                       clr_en_i,
  input  logic [ROW_IW-1:0]          clr_row_i,
  input  logic [BIT_W-1:0]           clr_bit_i,
  input  logic                       sum_clr_en_i,
  input  logic [ROW_IW-1:0]          sum_clr_row_i,
  output logic [ROWS-1:0][ROW_W-1:0] rows_o,
  output logic [ROWS-1:0]            sum_o
);
  logic [ROWS-1:0][ROW_W-1:0] bits_q;
  logic [ROWS-1:0]            sum_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit_set;
    assign hit_set = set_en_i && (set_row_i == ROW_IW'(r));

    // set wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bits_q[r] <= '0;
        sum_q[r]  <= 1'b0;
      end else begin
        if (clr_en_i && clr_row_i == ROW_IW'(r)) bits_q[r][clr_bit_i] <= 1'b0;
        if (hit_set) bits_q[r][set_bit_i] <= 1'b1;
        if (sum_clr_en_i && sum_clr_row_i == ROW_IW'(r)) sum_q[r] <= 1'b0;
        if (hit_set) sum_q[r] <= 1'b1;
      end
    end
  end

  assign rows_o = bits_q;
  assign sum_o  = sum_q;

  p_record_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> bits_q[$past(set_row_i)][$past(set_bit_i)] && sum_q[$past(set_row_i)])
    else $error("R1: reject not recorded");
endmodule

// File: rtl/rr_scan.sv
module rr_scan
  import rr_pkg::*;
#(
  parameter int ROWS  = 32,
  parameter int ROW_W = 64,
  localparam int ROW_IW = $clog2(ROWS),
  localparam int BIT_W  = $clog2(ROW_W),
  localparam int SRC_W  = ROW_IW + BIT_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       resend_i,
  input  logic [ROWS-1:0][ROW_W-1:0] rows_i,
  input  logic [ROWS-1:0]            sum_i,
  output logic                       clr_en_o,
  output logic [ROW_IW-1:0]          clr_row_o,
  output logic [BIT_W-1:0]           clr_bit_o,
  output logic                       sum_clr_en_o,
  output logic [ROW_IW-1:0]          sum_clr_row_o,
  output logic                       send_valid_o,
  input  logic                       send_ready_i,
  output logic [SRC_W-1:0]           send_src_o
);
  scan_st_e          st_q;
  logic [ROW_IW-1:0] row_q;
  logic [BIT_W:0]    ptr_q;   // one wider: ROW_W means row exhausted
  logic              vld_q;
  logic [SRC_W-1:0]  src_q;

  logic              row_hit, bit_hit;
  logic [ROW_IW-1:0] row_nxt;
  logic [BIT_W-1:0]  bit_nxt;
  logic [ROW_W-1:0]  cur_row;

  assign cur_row = rows_i[row_q];

  // next non-empty row at or after row_q
  always_comb begin
    row_hit = 1'b0;
    row_nxt = row_q;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (sum_i[i] && (i >= int'(row_q))) begin
        row_hit = 1'b1;
        row_nxt = ROW_IW'(i);
      end
    end
  end

  // next set bit at or after ptr_q in the current row
  always_comb begin
    bit_hit = 1'b0;
    bit_nxt = '0;
    for (int j = ROW_W - 1; j >= 0; j--) begin
      if (cur_row[j] && (j >= int'(ptr_q))) begin
        bit_hit = 1'b1;
        bit_nxt = BIT_W'(j);
      end
    end
  end

  assign clr_en_o      = (st_q == ST_BIT) && bit_hit;
  assign clr_row_o     = row_q;
  assign clr_bit_o     = bit_nxt;
  assign sum_clr_en_o  = (st_q == ST_ROW) && row_hit;
  assign sum_clr_row_o = row_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      row_q <= '0;
      ptr_q <= '0;
      vld_q <= 1'b0;
      src_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (resend_i && |sum_i) begin
          row_q <= '0;
          st_q  <= ST_ROW;
        end
        ST_ROW: begin
          if (row_hit) begin
            row_q <= row_nxt;
            ptr_q <= '0;
            st_q  <= ST_BIT;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_BIT: begin
          if (bit_hit) begin
            src_q <= {row_q, bit_nxt};
            vld_q <= 1'b1;
            ptr_q <= {1'b0, bit_nxt} + 1'b1;
            st_q  <= ST_OUT;
          end else if (row_q == ROW_IW'(ROWS - 1)) begin
            st_q <= ST_IDLE;
          end else begin
            row_q <= row_q + 1'b1;
            st_q  <= ST_ROW;
          end
        end
        ST_OUT: if (send_ready_i) begin
          vld_q <= 1'b0;
          st_q  <= ST_BIT;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign send_valid_o = vld_q;
  assign send_src_o   = src_q;

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_valid_o && !send_ready_i |=> send_valid_o && $stable(send_src_o))
    else $error("R6: trigger dropped or changed under backpressure");

  p_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) && resend_i && (sum_i == '0) |=> (st_q == ST_IDLE))
    else $error("R3: scan started with empty summary");

  p_clr_recorded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_o |-> rows_i[clr_row_o][clr_bit_o])
    else $error("R5: replay of an unrecorded source");
endmodule

// File: rtl/rr_replay.sv
module rr_replay #(
  parameter int ROWS  = 32,
  parameter int ROW_W = 64,
  parameter int IRQ_W = 20,
  localparam int SRC_W = $clog2(ROWS) + $clog2(ROW_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] base_i,
  input  logic             rej_valid_i,
  input  logic [IRQ_W-1:0] rej_irq_i,
  input  logic             resend_i,
  output logic             send_valid_o,
  input  logic             send_ready_i,
  output logic [SRC_W-1:0] send_src_o
);
  localparam int ROW_IW = $clog2(ROWS);
  localparam int BIT_W  = $clog2(ROW_W);

  logic                       set_en, clr_en, sum_clr_en;
  logic [ROW_IW-1:0]          set_row, clr_row, sum_clr_row;
  logic [BIT_W-1:0]           set_bit, clr_bit;
  logic [ROWS-1:0][ROW_W-1:0] rows;
  logic [ROWS-1:0]            sum;

  rr_decode #(.ROWS(ROWS), .ROW_W(ROW_W), .IRQ_W(IRQ_W)) u_dec (
    .rej_valid_i(rej_valid_i), .rej_irq_i(rej_irq_i), .base_i(base_i),
    .set_en_o(set_en), .set_row_o(set_row), .set_bit_o(set_bit)
  );

  rr_bitmap #(.ROWS(ROWS), .ROW_W(ROW_W)) u_map (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_en_i(set_en), .set_row_i(set_row), .set_bit_i(set_bit),
    .clr_en_i(clr_en), .clr_row_i(clr_row), .clr_bit_i(clr_bit),
    .sum_clr_en_i(sum_clr_en), .sum_clr_row_i(sum_clr_row),
    .rows_o(rows), .sum_o(sum)
  );

  rr_scan #(.ROWS(ROWS), .ROW_W(ROW_W)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .resend_i(resend_i),
    .rows_i(rows), .sum_i(sum),
    .clr_en_o(clr_en), .clr_row_o(clr_row), .clr_bit_o(clr_bit),
    .sum_clr_en_o(sum_clr_en), .sum_clr_row_o(sum_clr_row),
    .send_valid_o(send_valid_o), .send_ready_i(send_ready_i),
    .send_src_o(send_src_o)
  );
endmodule

// File: tb/sim_rr_replay.sv
module sim_rr_replay;
  localparam int IRQ_W = 20;
  localparam int SRC_W = 11;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [IRQ_W-1:0] base_i = '0;
  logic             rej_valid_i = 1'b0;
  logic [IRQ_W-1:0] rej_irq_i = '0;
  logic             resend_i = 1'b0;
  logic             send_valid_o;
  logic             send_ready_i = 1'b0;
  logic [SRC_W-1:0] send_src_o;

  int checks = 0;
  int failures = 0;
  int rdy_mode = 1;   // 0 low, 1 high, 2 toggling pattern
  int cyc = 0;
  int got[$];
  bit prev_stall = 0;
  logic [SRC_W-1:0] prev_src = '0;

  always #4 clk_i = ~clk_i;

  rr_replay u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_i),
    .rej_valid_i(rej_valid_i), .rej_irq_i(rej_irq_i), .resend_i(resend_i),
    .send_valid_o(send_valid_o), .send_ready_i(send_ready_i),
    .send_src_o(send_src_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ready driven shortly after each rising edge
  always begin
    @(posedge clk_i);
    #2;
    cyc++;
    send_ready_i = (rdy_mode == 1) || (rdy_mode == 2 && ((cyc & 1) ^ ((cyc >> 2) & 1)) == 1);
  end

  // monitor between edges: record handshakes, check hold under stall (R6)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_stall)
        check(send_valid_o && send_src_o == prev_src, "R6 hold", int'(send_src_o), int'(prev_src));
      if (send_valid_o && send_ready_i) got.push_back(int'(send_src_o));
      prev_stall = send_valid_o && !send_ready_i;
      prev_src   = send_src_o;
    end else begin
      prev_stall = 0;
    end
  end

  task automatic reject(input int irq);
    @(posedge clk_i); #2;
    rej_valid_i = 1'b1;
    rej_irq_i   = IRQ_W'(irq);
    @(posedge clk_i); #2;
    rej_valid_i = 1'b0;
  endtask

  task automatic resend();
    @(posedge clk_i); #2;
    resend_i = 1'b1;
    @(posedge clk_i); #2;
    resend_i = 1'b0;
  endtask

  task automatic settle();
    repeat (400) @(posedge clk_i);
  endtask

  task automatic expect_seq(input string req, input int exp[$]);
    check(got.size() == exp.size(), {req, " count"}, got.size(), exp.size());
    foreach (exp[i])
      if (i < got.size()) check(got[i] == exp[i], {req, " order"}, got[i], exp[i]);
    got.delete();
  endtask

  task automatic t_reset();   // R8, R3
    @(negedge clk_i);
    check(send_valid_o == 1'b0, "R8 valid in reset", int'(send_valid_o), 0);
    @(posedge clk_i); #2; rst_ni = 1'b1;
    @(negedge clk_i);
    check(send_valid_o == 1'b0, "R8 valid after reset", int'(send_valid_o), 0);
    resend(); settle();
    expect_seq("R3 empty resend", '{});
  endtask

  task automatic t_basic();   // R1, R4, R5
    base_i = 20'h100;
    reject('h100 + 5); reject('h100 + 70); reject('h100 + 3);
    reject('h100 + 2047); reject('h100 + 64);
    resend(); settle();
    expect_seq("R1 R4 ordered replay", '{3, 5, 64, 70, 2047});
    resend(); settle();
    expect_seq("R5 no second replay", '{});
  endtask

  task automatic t_range();   // R2
    reject('h100 - 1); reject('h100 + 2048); reject(0);
    resend(); settle();
    expect_seq("R2 out of range ignored", '{});
  endtask

  task automatic t_dup();     // R10
    reject('h100 + 9); reject('h100 + 9); reject('h100 + 9);
    resend(); settle();
    expect_seq("R10 duplicate once", '{9});
  endtask

  task automatic t_stall();   // R6, R4
    rdy_mode = 2;
    for (int k = 0; k < 10; k++) reject('h100 + 2000 - k * 150);
    resend(); settle();
    expect_seq("R6 R4 under backpressure",
               '{650, 800, 950, 1100, 1250, 1400, 1550, 1700, 1850, 2000});
    rdy_mode = 1;
  endtask

  task automatic t_during();  // R7, R9
    base_i = 20'h40;
    reject('h40 + 0); reject('h40 + 1); reject('h40 + 200); reject('h40 + 1000);
    rdy_mode = 0;
    resend();
    while (!send_valid_o) @(negedge clk_i);
    reject('h40 + 600);   // row ahead of scan
    resend();             // ignored, scan busy
    rdy_mode = 1;
    while (got.size() < 5) @(negedge clk_i);
    reject('h40 + 5);     // row already passed
    settle();
    expect_seq("R7 R9 reject during scan", '{0, 1, 200, 600, 1000});
    resend(); settle();
    expect_seq("R7 late reject next scan", '{5});
  endtask

  task automatic t_reset_mid();  // R8
    reject('h40 + 12); reject('h40 + 1500);
    @(posedge clk_i); #2; rst_ni = 1'b0;
    @(posedge clk_i); #2; rst_ni = 1'b1;
    resend(); settle();
    expect_seq("R8 reset clears store", '{});
  endtask

  initial begin
    t_reset();
    t_basic();
    t_range();
    t_dup();
    t_stall();
    t_during();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule